// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block stores the per-interrupt state of an interrupt distributor for `NUM_IRQ` lines (64 by default). For every line it keeps an enable bit, a pending bit, an active bit, an 8-bit priority and a trigger mode (level or edge). Software reaches this state through a plain register bus that carries a byte address, a byte count, write data and combinational read data. The bus decoder in front of the bank checks that an access is legal. The bank itself only interprets the address and the byte lanes.

Enable, pending and active each have a pair of register windows, one to set and one to clear. Each window takes a mask in which a one bit acts on its interrupt and a zero bit leaves it alone, and both windows of a pair read back the same state. Priorities are packed four to a word. Trigger modes are packed sixteen to a word, two bits each. The hardware side supplies the live level of every interrupt line. The bank presents the resulting state as flat vectors to the arbitration logic downstream.

For a level-triggered line, pending is the live line ORed with a software latch. For an edge-triggered line, pending is a sticky bit that a rising edge of the line sets. The lowest `NUM_PRIV` interrupts are private: they are always level-triggered, and configuration writes to them are dropped.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset every enable, pending, active and priority bit reads 0, and every interrupt is level-triggered.
- R2: In the set-enable window (byte 0x000 + 4·w) and the clear-enable window (0x080 + 4·w), bit b of word w stands for interrupt 32·w + b. Writing a one sets or clears that enable, and writing a zero leaves it unchanged. Both windows read back the enable bits.
- R3: A level-triggered interrupt reads pending (windows 0x100 set / 0x180 clear, same bit layout as R2) exactly when its line is high or its software latch is set. A set-pending write to a level-triggered interrupt sets the latch.
- R4: A clear-pending write to a level-triggered interrupt clears its latch, so that pending then equals the current line level.
- R5: An edge-triggered interrupt becomes pending in the cycle after its line rises, and stays pending after the line falls. A clear-pending write clears it even while the line is high.
- R6: In the set-active window (0x200) and the clear-active window (0x280), with the same bit layout as R2, ones set or clear the active bit and zeros have no effect. Both windows read back the active bits.
- R7: Priority word p at 0x400 + 4·p holds interrupt 4·p + k in bits 8k+7..8k. A write stores only the upper `PRI_BITS` bits of each byte and forces the lower bits to zero.
- R8: Configuration word c at 0xC00 + 4·c holds interrupt 16·c + j in bits 2j+1..2j. A write with bit 2j+1 set makes the interrupt edge-triggered, and with that bit clear makes it level-triggered. A read returns 2 in the pair for an edge interrupt and 0 for a level interrupt. Writes to interrupts below `NUM_PRIV` (32) are ignored. Switching an interrupt to level makes its pending equal to line OR latch.
- R9: A write acts only on the byte lanes from `bus_addr[1:0]` up to `bus_addr[1:0] + bus_len − 1`, where `bus_len` is a byte count of 1, 2 or 4. Bits in the other lanes have no effect.
- R10: Read data is combinational from the current state and reflects a write in the cycle after its strobe. Addresses outside every window, and words beyond `NUM_IRQ`, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address within the bank |
| bus_len | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_line | input | NUM_IRQ | Live level of each interrupt line, synchronous to clk |
| irq_enable | output | NUM_IRQ | Enable bit per interrupt |
| irq_pending | output | NUM_IRQ | Effective pending bit per interrupt |
| irq_active | output | NUM_IRQ | Active bit per interrupt |
| irq_edge | output | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| irq_prio | output | NUM_IRQ*8 | Priority byte per interrupt, interrupt i in bits 8i+7..8i |

## Verification
The assertions assume that `irq_line` is already synchronous to `clk`. They also assume that a full-word access uses `bus_len` = 4 with a word-aligned address, because the enable and active checks look only at aligned word writes. The bench changes the lines only in cycles without a bus write. It drives a byte count other than four only at the lane offsets it tests on purpose, which keeps the stimulus within these assumptions. For the edge-detection property, the lines also hold steady across the first cycle after reset.

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
  parameter int NUM_IRQ  = 64,
  parameter int PRI_BITS = 5,
  parameter int NUM_PRIV = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [2:0]           bus_len,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_IRQ-1:0]   irq_line,
  output logic [NUM_IRQ-1:0]   irq_enable,
  output logic [NUM_IRQ-1:0]   irq_pending,
  output logic [NUM_IRQ-1:0]   irq_active,
  output logic [NUM_IRQ-1:0]   irq_edge,
  output logic [NUM_IRQ*8-1:0] irq_prio
);
  localparam int NBW = NUM_IRQ / 32;
  localparam int NPW = NUM_IRQ / 4;
  localparam int NCW = NUM_IRQ / 16;
  localparam logic [7:0] PRI_MASK = 8'hFF << (8 - PRI_BITS);

  logic [7:0]  lane_full;
  logic [3:0]  lanes;
  logic [31:0] wd;
  logic [4:0]  bidx;
  logic [7:0]  pidx;
  logic [5:0]  cidx;
  logic [5:0]  wr_bit;
  logic        wr_pri, wr_cfg;

  logic [NUM_IRQ-1:0] en_q, act_q, soft_q, soft_d, pend_q, line_q, edge_q;

  assign lane_full = ((8'd1 << bus_len) - 8'd1) << bus_addr[1:0];
  assign lanes     = lane_full[3:0];
  assign wd        = bus_wdata & {{8{lanes[3]}}, {8{lanes[2]}}, {8{lanes[1]}}, {8{lanes[0]}}};
  assign bidx      = bus_addr[6:2];
  assign pidx      = bus_addr[9:2];
  assign cidx      = bus_addr[7:2];
  assign wr_pri    = bus_wr && bus_addr[11:10] == 2'b01;
  assign wr_cfg    = bus_wr && bus_addr[11:8] == 4'hC;

  for (genvar k = 0; k < 6; k++) begin : g_wsel
    assign wr_bit[k] = bus_wr && bus_addr[11:10] == 2'b00 && bus_addr[9:7] == 3'(k);
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    localparam int W  = i / 32;
    localparam int B  = i % 32;
    localparam int PW = i / 4;
    localparam int PL = i % 4;
    localparam int CW = i / 16;
    localparam int CL = i % 16;
    logic hit;
    assign hit = int'(bidx) == W && wd[B];

    always_comb begin
      soft_d[i] = soft_q[i];
      if (!edge_q[i] && wr_bit[2] && hit) soft_d[i] = 1'b1;
      if (!edge_q[i] && wr_bit[3] && hit) soft_d[i] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[i]   <= 1'b0;
        act_q[i]  <= 1'b0;
        soft_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
        line_q[i] <= 1'b0;
        irq_prio[8*i +: 8] <= 8'h00;
      end else begin
        line_q[i] <= irq_line[i];
        soft_q[i] <= soft_d[i];
        if (wr_bit[0] && hit) en_q[i] <= 1'b1;
        if (wr_bit[1] && hit) en_q[i] <= 1'b0;
        if (wr_bit[4] && hit) act_q[i] <= 1'b1;
        if (wr_bit[5] && hit) act_q[i] <= 1'b0;
        if (edge_q[i]) begin
          if (wr_bit[2] && hit) pend_q[i] <= 1'b1;
          if (wr_bit[3] && hit) pend_q[i] <= 1'b0;
          if (irq_line[i] && !line_q[i]) pend_q[i] <= 1'b1;
        end else begin
          pend_q[i] <= irq_line[i] | soft_d[i];
        end
        if (wr_pri && int'(pidx) == PW && lanes[PL])
          irq_prio[8*i +: 8] <= bus_wdata[8*PL +: 8] & PRI_MASK;
      end
    end

    if (i >= NUM_PRIV) begin : g_cfg
      always_ff @(posedge clk) begin
        if (!rst_n) edge_q[i] <= 1'b0;
        else if (wr_cfg && int'(cidx) == CW && lanes[CL/4])
          edge_q[i] <= bus_wdata[2*CL+1];
      end
    end else begin : g_priv
      assign edge_q[i] = 1'b0;
    end

    assign irq_pending[i] = edge_q[i] ? pend_q[i] : (irq_line[i] | soft_q[i]);
  end

  assign irq_enable = en_q;
  assign irq_active = act_q;
  assign irq_edge   = edge_q;

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_addr[11:10] == 2'b00 && int'(bidx) < NBW) begin
      case (bus_addr[9:7])
        3'd0, 3'd1: bus_rdata = en_q[32*int'(bidx) +: 32];
        3'd2, 3'd3: bus_rdata = irq_pending[32*int'(bidx) +: 32];
        3'd4, 3'd5: bus_rdata = act_q[32*int'(bidx) +: 32];
        default:    bus_rdata = 32'h0;
      endcase
    end else if (bus_addr[11:10] == 2'b01 && int'(pidx) < NPW) begin
      bus_rdata = irq_prio[32*int'(pidx) +: 32];
    end else if (bus_addr[11:8] == 4'hC && int'(cidx) < NCW) begin
      for (int j = 0; j < 16; j++) bus_rdata[2*j+1] = edge_q[16*int'(cidx) + j];
    end
  end
endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
  parameter int NUM_IRQ  = 64,
  parameter int PRI_BITS = 5,
  parameter int NUM_PRIV = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [11:0]          bus_addr,
  input logic [2:0]           bus_len,
  input logic [31:0]          bus_wdata,
  input logic [NUM_IRQ-1:0]   irq_line,
  input logic [NUM_IRQ-1:0]   irq_enable,
  input logic [NUM_IRQ-1:0]   irq_pending,
  input logic [NUM_IRQ-1:0]   irq_active,
  input logic [NUM_IRQ-1:0]   irq_edge,
  input logic [NUM_IRQ*8-1:0] irq_prio
);
  localparam logic [7:0] LOW_MASK = ~(8'hFF << (8 - PRI_BITS));

  p_set_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h000 && bus_len == 3'd4)
    |=> ((irq_enable[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  p_clear_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h280 && bus_len == 3'd4)
    |=> ((irq_active[31:0] & $past(bus_wdata)) == 32'h0));

  p_level_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq_edge & irq_line & ~irq_pending) == '0));

  p_private_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_edge[NUM_PRIV-1:0] == '0));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    p_prio_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_prio[8*i +: 8] & LOW_MASK) == 8'h00));

    p_edge_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_edge[i] && irq_line[i] && !$past(irq_line[i]) && !bus_wr)
      |=> irq_pending[i]);
  end
endmodule

bind irq_dist_regs irq_dist_regs_chk #(
  .NUM_IRQ(NUM_IRQ), .PRI_BITS(PRI_BITS), .NUM_PRIV(NUM_PRIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_len(bus_len), .bus_wdata(bus_wdata), .irq_line(irq_line),
  .irq_enable(irq_enable), .irq_pending(irq_pending), .irq_active(irq_active),
  .irq_edge(irq_edge), .irq_prio(irq_prio)
);

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb;
  localparam int CLK_P = 10;
  localparam int N = 64;
  localparam logic [7:0] PMASK = 8'hF8;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [2:0] bus_len = 3'd4;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] irq_line = 0, irq_enable, irq_pending, irq_active, irq_edge;
  logic [N*8-1:0] irq_prio;

  logic [N-1:0] m_en = 0, m_act = 0, m_soft = 0, m_ep = 0, m_edge = 0;
  logic [7:0] m_prio [N];
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_dist_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_len(bus_len), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_line(irq_line), .irq_enable(irq_enable), .irq_pending(irq_pending),
    .irq_active(irq_active), .irq_edge(irq_edge), .irq_prio(irq_prio));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_pend();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) p[i] = m_edge[i] ? m_ep[i] : (irq_line[i] | m_soft[i]);
    return p;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [31:0] r = 0;
    int w;
    if (a[11:10] == 2'b00) begin
      w = int'(a[6:2]);
      if (w < N/32)
        case (a[9:7])
          3'd0, 3'd1: r = m_en[32*w +: 32];
          3'd2, 3'd3: r = exp_pend() >> (32*w);
          3'd4, 3'd5: r = m_act[32*w +: 32];
          default: r = 0;
        endcase
    end else if (a[11:10] == 2'b01) begin
      w = int'(a[9:2]);
      if (w < N/4) for (int k = 0; k < 4; k++) r[8*k +: 8] = m_prio[4*w + k];
    end else if (a[11:8] == 4'hC) begin
      w = int'(a[7:2]);
      if (w < N/16) for (int j = 0; j < 16; j++) r[2*j +: 2] = m_edge[16*w + j] ? 2'd2 : 2'd0;
    end
    return r;
  endfunction

  task automatic model_wr(input logic [11:0] a, input int len, input logic [31:0] d);
    logic [3:0] ln;
    logic [31:0] wd;
    int id;
    ln = 4'(((8'd1 << len) - 8'd1) << a[1:0]);
    for (int k = 0; k < 4; k++) wd[8*k +: 8] = ln[k] ? d[8*k +: 8] : 8'h00;
    if (a[11:10] == 2'b00) begin
      for (int b = 0; b < 32; b++) begin
        id = 32*int'(a[6:2]) + b;
        if (id < N && wd[b])
          case (a[9:7])
            3'd0: m_en[id] = 1;
            3'd1: m_en[id] = 0;
            3'd2: if (m_edge[id]) m_ep[id] = 1; else m_soft[id] = 1;
            3'd3: if (m_edge[id]) m_ep[id] = 0; else m_soft[id] = 0;
            3'd4: m_act[id] = 1;
            3'd5: m_act[id] = 0;
            default: ;
          endcase
      end
    end else if (a[11:10] == 2'b01) begin
      for (int k = 0; k < 4; k++) begin
        id = 4*int'(a[9:2]) + k;
        if (ln[k] && id < N) m_prio[id] = d[8*k +: 8] & PMASK;
      end
    end else if (a[11:8] == 4'hC) begin
      for (int j = 0; j < 16; j++) begin
        id = 16*int'(a[7:2]) + j;
        if (id >= 32 && id < N && ln[j/4]) m_edge[id] = d[2*j+1];
      end
    end
    for (int i = 0; i < N; i++) if (!m_edge[i]) m_ep[i] = irq_line[i] | m_soft[i];
  endtask

  task automatic wr(input logic [11:0] a, input int len, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_len = 3'(len); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_len = 3'd4;
    model_wr(a, len, d);
  endtask

  task automatic set_line(input logic [N-1:0] v);
    logic [N-1:0] old;
    @(negedge clk);
    old = irq_line;
    irq_line = v;
    @(negedge clk);
    m_ep = m_ep | (m_edge & v & ~old);
    for (int i = 0; i < N; i++) if (!m_edge[i]) m_ep[i] = v[i] | m_soft[i];
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a);
    bus_addr = a; bus_len = 3'd4;
    #1;
    chk($sformatf("%s rd@%h", tag, a), 64'(bus_rdata), 64'(exp_rd(a)));
  endtask

  task automatic check_all(input string tag);
    for (int w = 0; w < 2; w++)
      for (int k = 0; k < 6; k++) rd_chk(tag, 12'(k*128 + 4*w));
    for (int p = 0; p < 16; p++) rd_chk(tag, 12'(12'h400 + 4*p));
    for (int c = 0; c < 4; c++) rd_chk(tag, 12'(12'hC00 + 4*c));
    chk({tag, " pending out"}, 64'(irq_pending), 64'(exp_pend()));
    chk({tag, " enable out"}, 64'(irq_enable), 64'(m_en));
    chk({tag, " active out"}, 64'(irq_active), 64'(m_act));
    chk({tag, " edge out"}, 64'(irq_edge), 64'(m_edge));
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_0F0F; pats[2] = 32'h0000_0001; pats[3] = 32'h8000_0000;
    for (int i = 0; i < N; i++) m_prio[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check_all("R1");
    chk("R1 prio out", 64'(|irq_prio), 64'd0);

    // R2: enable set/clear with masks
    for (int w = 0; w < 2; w++)
      for (int p = 0; p < 4; p++) begin
        wr(12'(4*w), 4, pats[p] ^ 32'(w*32'h1111_0000));
        check_all("R2");
        wr(12'(12'h080 + 4*w), 4, pats[(p+1)%4]);
        check_all("R2");
      end
    wr(12'h000, 4, 32'hFFFF_FFFF);
    wr(12'h000, 4, 32'h0);
    check_all("R2 zero-write");

    // R9: byte lanes
    wr(12'h202, 1, 32'hFFFF_FFFF);
    check_all("R9");
    chk("R9 active lane2", 64'(irq_active[31:0]), 64'h00FF_0000);
    wr(12'h401, 2, 32'hFFFF_FFFF);
    check_all("R9");
    wr(12'h087, 1, 32'hFFFF_FFFF);
    check_all("R9");

    // R7: priorities with narrowing
    for (int p = 0; p < 16; p++) begin
      wr(12'(12'h400 + 4*p), 4, 32'(p) * 32'h0931_7D0B + 32'h1F3E_5D7C);
    end
    check_all("R7");
    wr(12'h404, 4, 32'hFFFF_FFFF);
    rd_chk("R7", 12'h404);
    chk("R7 narrow", 64'(irq_prio[63:32]), 64'hF8F8_F8F8);

    // R8: configuration, private words ignored
    for (int c = 0; c < 4; c++) wr(12'(12'hC00 + 4*c), 4, 32'hFFFF_FFFF);
    check_all("R8");
    chk("R8 edge map", 64'(irq_edge), 64'hFFFF_FFFF_0000_0000);

    // R3: level pending = line | latch on private ids
    set_line(64'h0000_0000_00F0_F00F);
    check_all("R3");
    wr(12'h100, 4, 32'h0F00_0F00);
    check_all("R3");
    set_line(64'h0000_0000_0000_0000);
    check_all("R3");
    chk("R3 latch only", 64'(irq_pending[31:0]), 64'h0F00_0F00);

    // R4: clear-pending resamples line
    set_line(64'h0000_0000_0300_0001);
    wr(12'h180, 4, 32'hFFFF_FFFF);
    check_all("R4");
    chk("R4 equals line", 64'(irq_pending[31:0]), 64'h0300_0001);

    // R5: edge-triggered pending on ids 32..63
    set_line(64'hF0F0_F0F0_0000_0000);
    check_all("R5");
    set_line(64'h0000_0000_0000_0000);
    check_all("R5");
    chk("R5 sticky", 64'(irq_pending[63:32]), 64'hF0F0_F0F0);
    set_line(64'hFFFF_FFFF_0000_0000);
    wr(12'h184, 4, 32'hFFFF_FFFF);
    check_all("R5");
    chk("R5 clear with line high", 64'(irq_pending[63:32]), 64'h0);
    wr(12'h104, 4, 32'h0000_8001);
    check_all("R5");

    // R8: switching back to level recomputes pending
    set_line(64'h0000_FF00_0000_0000);
    wr(12'hC08, 4, 32'h0);
    check_all("R8");
    chk("R8 level recompute", 64'(irq_pending[47:32]), 64'hFF00);

    // R6: active set/clear
    for (int p = 0; p < 4; p++) begin
      wr(12'h204, 4, pats[p]);
      check_all("R6");
      wr(12'h280, 4, pats[(p+2)%4]);
      check_all("R6");
    end

    // R10: unmapped or out-of-range reads return 0
    wr(12'h000, 4, 32'hFFFF_FFFF);
    rd_chk("R10", 12'h300);
    rd_chk("R10", 12'h008);
    rd_chk("R10", 12'h440);
    rd_chk("R10", 12'h800);
    rd_chk("R10", 12'hC10);
    bus_addr = 12'h000; #1;
    chk("R10 same-cycle read", 64'(bus_rdata), 64'hFFFF_FFFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule